// File: doc/BRIEF.md
# Keyed Watchdog Timer with Register Lock

This block is a system watchdog driven through a small byte-wide write interface. A slow reference strobe (one pulse per reference clock period, synchronous to `clk`) feeds a prescaler. The prescaler output, or the raw strobe, decrements a 16-bit watchdog counter. Software arms the counter by writing its period, high byte first and low byte second. The low-byte write starts the count. From then on, software keeps the system alive by writing a fixed key byte before the count runs out. When the count does run out, the block raises a one-cycle reset request and stops.

A configuration register controls three things: whether key matching is enabled, which tick source the watchdog uses, and whether the other watchdog registers are locked against writes. A separate gate, "timer 1", must be started before the watchdog counts at all. A control register can make the watchdog stoppable and halt it. An independent early-warning timer counts prescaled ticks and raises an interrupt pulse each time its programmed interval elapses. It then reloads itself, so it fires repeatedly until it is disabled or restarted.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `wdt_rst_req` and `warn_irq` are 0, all registers are unlocked, and the watchdog is stopped: no reset request follows, however many reference pulses arrive.
- R2: Register addresses are: CFG 0x00, PSEL 0x01, CTRL 0x02, PERIOD_HI 0x03, PERIOD_LO 0x04, KEY 0x05, WCTRL 0x06, WRELOAD_HI 0x07, WRELOAD_LO 0x08, T1GO 0x09. The lock is active when CFG bits [3:0] are all ones. While the lock is active, writes to PSEL, CTRL, PERIOD_HI, PERIOD_LO and T1GO are ignored. CFG, KEY and the warning registers stay writable.
- R3: A write to PERIOD_LO loads the period {PERIOD_HI, data} and starts the watchdog. With timer 1 started, the reset request appears after exactly P watchdog ticks.
- R4: The reset request lasts exactly one clock cycle. The watchdog then stays stopped until PERIOD_LO is written again.
- R5: While the watchdog runs and CFG bit 5 is set, writing 0x5C to KEY reloads the count to the programmed period. Any other key value, or any key write while CFG bit 5 is clear, has no effect.
- R6: The watchdog counts only after T1GO has been written. Ticks that arrive before that are lost.
- R7: PSEL bit 0 = 1 divides reference pulses by REF_DIV. PSEL bit 0 = 0 passes every pulse through. CFG bit 4 = 1 clocks the watchdog from the prescaler output; CFG bit 4 = 0 clocks it from the raw reference pulses.
- R8: CTRL bit 0 halts the count only when CTRL bit 4 (stoppable) is also set. When halting is lifted, the count resumes from where it stopped. With bit 4 clear, bit 0 is ignored.
- R9: A WCTRL write with bits [1:0] = 0b11 enables the warning timer and restarts it from {WRELOAD_HI, WRELOAD_LO}. The timer raises a one-cycle `warn_irq` every W prescaler ticks and reloads itself each time. A WCTRL write with bit 0 clear disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| wdt_rst_req | output | 1 | One-cycle watchdog expiry request |
| warn_irq | output | 1 | One-cycle early-warning interrupt |

## Verification
The bench aims at the off-by-one edges of expiry. A counter that fires one tick early or late, or that holds the request for more than a cycle, shows up as an event tagged with the wrong reference-pulse index. Locked writes that would re-arm or halt the counter are issued while the lock is active: a lock that leaks moves or removes the expected reset. A wrong or disabled key, a halt bit without the stoppable bit, and ticks that arrive before timer 1 starts are all sent as well, and each would move the expiry time if it were wrongly honoured. A mid-interval warning restart and the later disable show whether the warning timer reloads and stops correctly.

// File: rtl/kwdt_pkg.sv
// Shared register addresses, bit positions and key constant for the keyed watchdog.
package kwdt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CFG     = 8'h00;
    localparam logic [ADDR_W-1:0] A_PSEL    = 8'h01;
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h02;
    localparam logic [ADDR_W-1:0] A_PER_HI  = 8'h03;
    localparam logic [ADDR_W-1:0] A_PER_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] A_KEY     = 8'h05;
    localparam logic [ADDR_W-1:0] A_WCTRL   = 8'h06;
    localparam logic [ADDR_W-1:0] A_WREL_HI = 8'h07;
    localparam logic [ADDR_W-1:0] A_WREL_LO = 8'h08;
    localparam logic [ADDR_W-1:0] A_T1GO    = 8'h09;

    localparam logic [DATA_W-1:0] KEY_VALUE = 8'h5C;

    localparam int CFG_TSEL_BIT  = 4;
    localparam int CFG_KEYEN_BIT = 5;
    localparam int CTRL_HALT_BIT = 0;
    localparam int CTRL_STOP_BIT = 4;
    localparam int WCTRL_EN_BIT  = 0;
    localparam int WCTRL_RS_BIT  = 1;
endpackage

// File: rtl/kwdt_regfile.sv
// Register decode and lock for the keyed watchdog.
// Holds the configuration, prescaler select, control, period and warning reload
// registers, plus the timer-1 run flag. It emits one-cycle strobes for arm, key
// write and warning restart. Assumes a single-cycle write strobe synchronous to clk.
module kwdt_regfile
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_en,
    output logic              tick_sel,
    output logic              div_en,
    output logic              stop_ok,
    output logic              halt_req,
    output logic              t1_run,
    output logic              arm,
    output logic [CNT_W-1:0]  arm_value,
    output logic [CNT_W-1:0]  period,
    output logic              key_wr,
    output logic [DATA_W-1:0] key_data,
    output logic              warn_en,
    output logic              warn_restart,
    output logic [CNT_W-1:0]  warn_reload
);
    logic [DATA_W-1:0] cfg_q, psel_q, ctrl_q, per_hi_q, wrel_hi_q, wrel_lo_q;
    logic [CNT_W-1:0]  period_q;
    logic              t1_q, wen_q;
    logic              locked, sel_guarded;

    // Lock is active when the low four configuration bits are all ones.
    assign locked = &cfg_q[3:0];

    // A write to one of the lock-protected registers is only honoured while unlocked.
    assign sel_guarded = wr_en && !locked;

    // Strobes and values consumed by the counter and warning timer in the same edge.
    always_comb begin
        arm          = sel_guarded && (wr_addr == A_PER_LO);
        arm_value    = {per_hi_q, wr_data};
        key_wr       = wr_en && (wr_addr == A_KEY);
        key_data     = wr_data;
        warn_restart = wr_en && (wr_addr == A_WCTRL)
                       && wr_data[WCTRL_RS_BIT] && wr_data[WCTRL_EN_BIT];
    end

    // Register writes, with the lock applied to the watchdog-owned registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            psel_q    <= '0;
            ctrl_q    <= '0;
            per_hi_q  <= '0;
            period_q  <= '0;
            t1_q      <= 1'b0;
            wen_q     <= 1'b0;
            wrel_hi_q <= '0;
            wrel_lo_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CFG:     cfg_q <= wr_data;
                A_PSEL:    if (!locked) psel_q <= wr_data;
                A_CTRL:    if (!locked) ctrl_q <= wr_data;
                A_PER_HI:  if (!locked) per_hi_q <= wr_data;
                A_PER_LO:  if (!locked) period_q <= {per_hi_q, wr_data};
                A_T1GO:    if (!locked) t1_q <= 1'b1;
                A_WCTRL:   wen_q <= wr_data[WCTRL_EN_BIT];
                A_WREL_HI: wrel_hi_q <= wr_data;
                A_WREL_LO: wrel_lo_q <= wr_data;
                default:   ;
            endcase
        end
    end

    // Field extraction for the downstream blocks.
    always_comb begin
        key_en      = cfg_q[CFG_KEYEN_BIT];
        tick_sel    = cfg_q[CFG_TSEL_BIT];
        div_en      = psel_q[0];
        stop_ok     = ctrl_q[CTRL_STOP_BIT];
        halt_req    = ctrl_q[CTRL_HALT_BIT];
        t1_run      = t1_q;
        period      = period_q;
        warn_en     = wen_q;
        warn_reload = {wrel_hi_q, wrel_lo_q};
    end

    AST_LOCK_HOLDS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(period_q)) else $error("period changed under lock"); // R2
    AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(ctrl_q) && $stable(psel_q))) else $error("ctrl/psel changed under lock"); // R2
endmodule

// File: rtl/kwdt_prescaler.sv
// Reference-pulse prescaler.
// Produces a registered divided tick (one every DIV pulses when div_en is set,
// otherwise one per pulse) and a registered copy of the raw pulse, so both tick
// sources have the same latency. Assumes ref_pulse is a one-cycle strobe.
module kwdt_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic div_en,
    output logic pre_tick,
    output logic raw_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    // Divide counter; cleared and bypassed while division is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q   <= '0;
            pre_tick <= 1'b0;
            raw_tick <= 1'b0;
        end else begin
            raw_tick <= ref_pulse;
            pre_tick <= 1'b0;
            if (!div_en) begin
                pcnt_q   <= '0;
                pre_tick <= ref_pulse;
            end else if (ref_pulse) begin
                if (pcnt_q == LAST) begin
                    pcnt_q   <= '0;
                    pre_tick <= 1'b1;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end
        end
    end

    AST_PRE_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> raw_tick) else $error("prescaled tick without reference pulse"); // R7
endmodule

// File: rtl/kwdt_counter.sv
// Watchdog down-counter with key reload.
// Loads on arm, reloads on a matching key while running, and decrements on
// each gated tick. At expiry it emits a one-cycle request and stops.
// Assumes arm and key strobes are never high together (distinct addresses).
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              t1_run,
    input  logic              stop_ok,
    input  logic              halt_req,
    input  logic              key_en,
    input  logic              arm,
    input  logic [CNT_W-1:0]  arm_value,
    input  logic [CNT_W-1:0]  period,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              rst_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             key_ok, step;

    // A key only counts when matching is enabled, the value is right and we run.
    assign key_ok = key_wr && key_en && (key_data == KEY_VALUE) && run_q;
    // Count only with timer 1 started and no effective halt.
    assign step   = tick && run_q && t1_run && !(stop_ok && halt_req);

    // Arm, key reload, decrement and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (arm) begin
                cnt_q <= arm_value;
                run_q <= 1'b1;
            end else if (key_ok) begin
                cnt_q <= period;
            end else if (step) begin
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_q   <= '0;
                    run_q   <= 1'b0;
                    rst_req <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req) else $error("reset request wider than one cycle"); // R4
    AST_RST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !run_q) else $error("counter still running after expiry"); // R4
    AST_RST_NEEDS_T1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(t1_run)) else $error("expiry without timer 1"); // R6
    AST_KEY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> (cnt_q == $past(period))) else $error("key did not reload"); // R5
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ok && halt_req && !arm && !key_ok) |=> $stable(cnt_q)) else $error("count moved while halted"); // R8
endmodule

// File: rtl/kwdt_warn.sv
// Early-warning interval timer.
// Counts prescaled ticks from its reload value and pulses irq for one cycle
// each time the interval elapses, then reloads. A restart strobe reloads it.
module kwdt_warn #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             irq
);
    logic [CNT_W-1:0] wcnt_q;

    // Restart, decrement and auto-reload with interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (restart) begin
                wcnt_q <= reload;
            end else if (enable && tick) begin
                if (wcnt_q <= CNT_W'(1)) begin
                    wcnt_q <= reload;
                    irq    <= 1'b1;
                end else begin
                    wcnt_q <= wcnt_q - 1'b1;
                end
            end
        end
    end

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick && enable)) else $error("warning without enabled tick"); // R9
    AST_IRQ_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (wcnt_q == $past(reload))) else $error("warning timer did not reload"); // R9
endmodule

// File: rtl/keyed_wdt.sv
// Keyed watchdog timer top.
// Connects the register file, prescaler, watchdog counter and warning timer.
// Assumes ref_pulse is a one-cycle strobe synchronous to clk.
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int REF_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdt_rst_req,
    output logic              warn_irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic             key_en, tick_sel, div_en, stop_ok, halt_req, t1_run;
    logic             arm, key_wr, warn_en, warn_restart;
    logic [CNT_W-1:0] arm_value, period, warn_reload;
    logic [DATA_W-1:0] key_data;
    logic             pre_tick, raw_tick, wd_tick;

    kwdt_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .key_en(key_en), .tick_sel(tick_sel), .div_en(div_en), .stop_ok(stop_ok),
        .halt_req(halt_req), .t1_run(t1_run), .arm(arm), .arm_value(arm_value),
        .period(period), .key_wr(key_wr), .key_data(key_data), .warn_en(warn_en),
        .warn_restart(warn_restart), .warn_reload(warn_reload)
    );

    kwdt_prescaler #(.DIV(REF_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_en(div_en),
        .pre_tick(pre_tick), .raw_tick(raw_tick)
    );

    // Watchdog tick source chosen by the configuration register.
    assign wd_tick = tick_sel ? pre_tick : raw_tick;

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(wd_tick), .t1_run(t1_run), .stop_ok(stop_ok),
        .halt_req(halt_req), .key_en(key_en), .arm(arm), .arm_value(arm_value),
        .period(period), .key_wr(key_wr), .key_data(key_data), .rst_req(wdt_rst_req)
    );

    kwdt_warn #(.CNT_W(CNT_W)) u_warn (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick), .enable(warn_en),
        .restart(warn_restart), .reload(warn_reload), .irq(warn_irq)
    );
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wdt_rst_req, warn_irq;

    int n_checks = 0;
    int n_fails  = 0;
    int ref_idx  = 0;
    bit rst_prev = 1'b0;

    typedef struct { bit is_irq; int idx; string req; } ev_t;
    ev_t exp_q[$];

    keyed_wdt #(.REF_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wdt_rst_req(wdt_rst_req), .warn_irq(warn_irq)
    );

    always #2.5 clk = ~clk;

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        n_fails++;
        $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; wr_en = 1'b0; ref_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        exp_q.delete();
        ref_idx = 0;
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ref_pulse = 1'b1; ref_idx++;
            @(posedge clk); #1;
            ref_pulse = 1'b0;
            repeat (4) @(posedge clk);
        end
    endtask

    // Driver side of the scoreboard: an expected event at a reference-pulse index.
    task automatic expect_ev(input bit is_irq, input int idx, input string req);
        ev_t e;
        e.is_irq = is_irq; e.idx = idx; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic end_scn(input string req);
        repeat (6) @(posedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            fail_line(req, "missing expected events", 0, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic handle(input bit is_irq);
        ev_t e;
        n_checks++;
        if (exp_q.size() == 0) begin
            fail_line(is_irq ? "R9" : "R3", "unexpected event at pulse", ref_idx, -1);
        end else begin
            e = exp_q.pop_front();
            if (e.is_irq != is_irq)
                fail_line(e.req, "event kind (1=irq)", is_irq, e.is_irq);
            else if (e.idx != ref_idx)
                fail_line(e.req, "event pulse index", ref_idx, e.idx);
        end
    endtask

    // Monitor side of the scoreboard, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_rst_req) handle(1'b0);
            if (warn_irq) handle(1'b1);
            if (wdt_rst_req && rst_prev) begin
                n_checks++;
                fail_line("R4", "reset request width over one cycle", 2, 1);
            end
            rst_prev = wdt_rst_req;
        end else begin
            rst_prev = 1'b0;
        end
    end

    initial begin
        #(5.0 * 200000);
        fail_line("WATCHDOG", "bench timed out", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state and stopped watchdog.
        do_reset();
        @(negedge clk);
        n_checks++; if (wdt_rst_req !== 1'b0) fail_line("R1", "wdt_rst_req after reset", wdt_rst_req, 0);
        n_checks++; if (warn_irq !== 1'b0) fail_line("R1", "warn_irq after reset", warn_irq, 0);
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h30); write_reg(8'h09, 8'h00);
        pulses(40);
        end_scn("R1");

        // R3/R4: arm with period 3 prescaled ticks, single expiry then stop.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h30); write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h03);
        expect_ev(1'b0, 12, "R3");
        pulses(40);
        end_scn("R4");

        // R6: ticks before timer 1 starts are lost.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h30);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h03);
        pulses(30);
        write_reg(8'h09, 8'h00);
        expect_ev(1'b0, 40, "R6");
        pulses(14);
        end_scn("R6");

        // R5: good key reloads, wrong key ignored.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h30); write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h05);
        expect_ev(1'b0, 32, "R5");
        pulses(14);
        write_reg(8'h05, 8'h5C);
        pulses(12);
        write_reg(8'h05, 8'h12);
        pulses(10);
        end_scn("R5");

        // R5: key ignored while matching disabled.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h10); write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h03);
        expect_ev(1'b0, 12, "R5");
        pulses(6);
        write_reg(8'h05, 8'h5C);
        pulses(10);
        end_scn("R5");

        // R2: locked writes ignored, unlock then re-arm.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h30); write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h03);
        write_reg(8'h00, 8'h3F);
        write_reg(8'h03, 8'h01); write_reg(8'h04, 8'h0A); write_reg(8'h02, 8'h11);
        expect_ev(1'b0, 12, "R2");
        pulses(16);
        write_reg(8'h04, 8'h02);
        pulses(16);
        write_reg(8'h00, 8'h30);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h02);
        expect_ev(1'b0, 40, "R2");
        pulses(8);
        end_scn("R2");

        // R7: raw reference pulses as watchdog tick.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h20); write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h03);
        expect_ev(1'b0, 3, "R7");
        pulses(8);
        end_scn("R7");

        // R7: prescaler division off passes every pulse.
        do_reset();
        write_reg(8'h01, 8'h00); write_reg(8'h00, 8'h30); write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h03);
        expect_ev(1'b0, 3, "R7");
        pulses(8);
        end_scn("R7");

        // R8: halt honoured only when stoppable.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h30); write_reg(8'h02, 8'h11);
        write_reg(8'h09, 8'h00);
        write_reg(8'h03, 8'h00); write_reg(8'h04, 8'h02);
        pulses(20);
        write_reg(8'h02, 8'h10);
        expect_ev(1'b0, 28, "R8");
        pulses(8);
        write_reg(8'h02, 8'h01);
        write_reg(8'h04, 8'h02);
        expect_ev(1'b0, 36, "R8");
        pulses(12);
        end_scn("R8");

        // R9: warning timer under lock, restart, repeat and disable.
        do_reset();
        write_reg(8'h01, 8'h01); write_reg(8'h00, 8'h3F);
        write_reg(8'h07, 8'h00); write_reg(8'h08, 8'h03);
        write_reg(8'h06, 8'h03);
        pulses(10);
        write_reg(8'h06, 8'h03);
        expect_ev(1'b1, 20, "R9");
        expect_ev(1'b1, 32, "R9");
        expect_ev(1'b1, 44, "R9");
        pulses(34);
        write_reg(8'h06, 8'h00);
        pulses(20);
        end_scn("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule